// File: doc/BRIEF.md
# CAN Error, Overload and Interframe Gap Sequencer

This block produces the bus bits that a CAN node drives once an error or overload condition has been found. It also paces the recessive gap that separates frames. When an error is requested, the node sends a dominant flag if it is error-active, or a recessive flag if it is error-passive. An overload request sends a dominant overload flag. After either flag comes a recessive delimiter, then the intermission, and then, when the node is error-passive and was the last transmitter, a suspend-transmission period. At the end the block reports that the bus is free.

Every decision is taken on a one-clock bit-tick strobe. At that strobe the block samples the bus value of the bit that has just ended and chooses the value it will drive for the next bit. Frame parsing, error counting and bit timing are handled elsewhere. That logic drives the request inputs and the error-passive and was-transmitter status. The overload and early start-of-frame pulses tell it what the gap logic has seen on the bus.

Top module: `can_gap_seq`

## Requirements
- R1: An error request taken with `err_passive` low makes `tx_bit` dominant (0) for exactly 6 bit ticks, starting with the bit that follows the request tick, and recessive afterwards.
- R2: With `err_passive` high, an error request keeps `tx_bit` recessive (1) and holds `busy` high. The flag phase ends only on the tick that completes 6 consecutive equal sampled bus bits, whatever their value.
- R3: After a flag, the delimiter starts at the first recessive bus bit. Dominant bits from other nodes that overlap the flag, up to 12 in total, only delay that start. The delimiter is 8 recessive bits long in all.
- R4: An overload request taken while idle or during the intermission drives 6 dominant bits, followed by the 8-bit delimiter and the 3-bit intermission.
- R5: When no suspend period applies, `bus_idle` rises and `busy` falls on the tick that samples the third intermission bit as recessive. That is tick 17 after the request tick for an unextended dominant flag.
- R6: A dominant bus bit sampled on the first or second intermission bit gives a one-clock `ovl_flag` pulse, and the next driven bit starts an overload flag (`tx_bit` = 0).
- R7: A dominant bus bit sampled on the third intermission bit gives a one-clock `early_sof` pulse with no `ovl_flag`. The block returns to idle with `tx_bit` recessive.
- R8: When `was_tx` and `err_passive` are both high at the end of the intermission, 8 further recessive bits pass before `bus_idle` rises. A dominant bus bit during that period gives an `early_sof` pulse and ends it at once.
- R9: Synchronous reset gives `tx_bit`=1, `busy`=0, `bus_idle`=1 and both pulses 0. With `bit_tick` low, no input changes any output.
- R10: An error request outranks an overload request on the same tick. An error request during the intermission starts its flag on the very next bit, with no gap inserted first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-clock strobe at each bit sample point |
| rx_bit | input | 1 | Sampled bus value of the bit just ended (0 = dominant) |
| err_passive | input | 1 | Node is error-passive |
| err_req | input | 1 | Error detected; start an error flag |
| ovl_req | input | 1 | Receiver not ready; start an overload flag |
| was_tx | input | 1 | Node transmitted the frame that preceded this gap |
| tx_bit | output | 1 | Bit to drive on the bus (0 = dominant) |
| busy | output | 1 | A flag, delimiter, intermission or suspend is in progress |
| bus_idle | output | 1 | Gap finished; the node may start or receive a frame |
| ovl_flag | output | 1 | One-clock pulse: dominant seen on intermission bit 1 or 2 |
| early_sof | output | 1 | One-clock pulse: dominant taken as start of frame |

## Verification
The assertions assume that `bit_tick` is a single-clock strobe and that `rx_bit`, `err_req`, `ovl_req` and the status inputs are stable at that strobe. They also assume that `rx_bit` is the wired-AND of this node's `tx_bit` with the other nodes. If the bus reported recessive while the node drove dominant, the flag-length property would still hold, but delimiter timing would be meaningless. The stimulus therefore builds each sampled bit as the current `tx_bit` ANDed with a modelled contribution from the other nodes. It changes inputs only between strobes and always separates strobes by at least one idle clock.

// File: rtl/can_gap_pkg.sv
package can_gap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FLAG_DOM,
    ST_FLAG_REC,
    ST_DLM_WAIT,
    ST_DLM_CNT,
    ST_INTERM,
    ST_SUSPEND
  } gap_state_t;
endpackage

// File: rtl/can_phase_ctr.sv
module can_phase_ctr #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                   cnt_q <= '0;
    else if (load)             cnt_q <= load_val;
    else if (dec && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/can_equal_run.sv
module can_equal_run #(
  parameter int RUN = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  input  logic bit_in,
  output logic hit
);
  localparam int RW = $clog2(RUN + 1);
  logic [RW-1:0] run_q;
  logic          last_q;
  logic          same;

  assign same = (run_q != '0) && (bit_in == last_q);
  assign hit  = same ? (run_q == RW'(RUN - 1)) : (RUN == 1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      run_q  <= '0;
      last_q <= 1'b1;
    end else if (step) begin
      last_q <= bit_in;
      if (same) begin
        if (run_q != RW'(RUN)) run_q <= run_q + 1'b1;
      end else begin
        run_q <= RW'(1);
      end
    end
  end
endmodule

// File: rtl/can_gap_seq.sv
module can_gap_seq
  import can_gap_pkg::*;
#(
  parameter int FLAG_BITS    = 6,
  parameter int DELIM_BITS   = 8,
  parameter int INTERM_BITS  = 3,
  parameter int SUSPEND_BITS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_tick,
  input  logic rx_bit,
  input  logic err_passive,
  input  logic err_req,
  input  logic ovl_req,
  input  logic was_tx,
  output logic tx_bit,
  output logic busy,
  output logic bus_idle,
  output logic ovl_flag,
  output logic early_sof
);
  localparam int CW = $clog2(FLAG_BITS + DELIM_BITS + INTERM_BITS + SUSPEND_BITS + 1);

  gap_state_t    state_q, state_d;
  logic          ld, dec, ctr_zero, run_clr, run_hit;
  logic [CW-1:0] ld_val;
  logic          start_err, start_ovl, ovl_ev, sof_ev;

  can_phase_ctr #(.W(CW)) u_ctr (
    .clk(clk), .rst(rst), .load(ld), .load_val(ld_val), .dec(dec), .zero(ctr_zero)
  );

  can_equal_run #(.RUN(FLAG_BITS)) u_run (
    .clk(clk), .rst(rst), .clr(run_clr),
    .step(bit_tick && state_q == ST_FLAG_REC), .bit_in(rx_bit), .hit(run_hit)
  );

  always_comb begin
    state_d   = state_q;
    ld        = 1'b0;
    ld_val    = '0;
    dec       = 1'b0;
    run_clr   = 1'b0;
    start_err = 1'b0;
    start_ovl = 1'b0;
    ovl_ev    = 1'b0;
    sof_ev    = 1'b0;
    if (bit_tick) begin
      unique case (state_q)
        ST_IDLE: begin
          if (err_req)      start_err = 1'b1;
          else if (ovl_req) start_ovl = 1'b1;
        end
        ST_FLAG_DOM: begin
          if (ctr_zero) state_d = ST_DLM_WAIT;
          else          dec = 1'b1;
        end
        ST_FLAG_REC: begin
          if (run_hit) state_d = ST_DLM_WAIT;
        end
        ST_DLM_WAIT: begin
          if (rx_bit) begin
            state_d = ST_DLM_CNT;
            ld      = 1'b1;
            ld_val  = CW'(DELIM_BITS - 2);
          end
        end
        ST_DLM_CNT: begin
          if (err_req) start_err = 1'b1;
          else if (ctr_zero) begin
            state_d = ST_INTERM;
            ld      = 1'b1;
            ld_val  = CW'(INTERM_BITS - 1);
          end else dec = 1'b1;
        end
        ST_INTERM: begin
          if (err_req) start_err = 1'b1;
          else if (!rx_bit) begin
            if (!ctr_zero) begin
              ovl_ev    = 1'b1;
              start_ovl = 1'b1;
            end else begin
              sof_ev  = 1'b1;
              state_d = ST_IDLE;
            end
          end else if (ovl_req) start_ovl = 1'b1;
          else if (ctr_zero) begin
            if (was_tx && err_passive) begin
              state_d = ST_SUSPEND;
              ld      = 1'b1;
              ld_val  = CW'(SUSPEND_BITS - 1);
            end else state_d = ST_IDLE;
          end else dec = 1'b1;
        end
        ST_SUSPEND: begin
          if (err_req) start_err = 1'b1;
          else if (!rx_bit) begin
            sof_ev  = 1'b1;
            state_d = ST_IDLE;
          end else if (ctr_zero) state_d = ST_IDLE;
          else dec = 1'b1;
        end
        default: state_d = ST_IDLE;
      endcase
      if (start_err && err_passive) begin
        state_d = ST_FLAG_REC;
        run_clr = 1'b1;
      end else if (start_err || start_ovl) begin
        state_d = ST_FLAG_DOM;
        ld      = 1'b1;
        ld_val  = CW'(FLAG_BITS - 1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      tx_bit    <= 1'b1;
      busy      <= 1'b0;
      bus_idle  <= 1'b1;
      ovl_flag  <= 1'b0;
      early_sof <= 1'b0;
    end else begin
      ovl_flag  <= bit_tick && ovl_ev;
      early_sof <= bit_tick && sof_ev;
      if (bit_tick) begin
        state_q  <= state_d;
        tx_bit   <= (state_d != ST_FLAG_DOM);
        busy     <= (state_d != ST_IDLE);
        bus_idle <= (state_d == ST_IDLE);
      end
    end
  end

  // Checker state: consecutive bit ticks during which the node drives dominant.
  logic [CW-1:0] dom_run_q;
  always_ff @(posedge clk) begin
    if (rst)           dom_run_q <= '0;
    else if (bit_tick) dom_run_q <= tx_bit ? '0 : dom_run_q + 1'b1;
  end

  a_r1_dom_run_bounded: assert property (@(posedge clk) disable iff (rst)
    dom_run_q <= CW'(FLAG_BITS));

  a_r2_passive_recessive: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FLAG_REC) |-> tx_bit);

  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    bus_idle |-> (tx_bit && !busy));

  a_r6_ovl_drives_dom: assert property (@(posedge clk) disable iff (rst)
    ovl_flag |-> !tx_bit);

  a_r7_pulses_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({early_sof, ovl_flag}));

  a_r7_sof_returns_idle: assert property (@(posedge clk) disable iff (rst)
    early_sof |-> bus_idle);

  a_r9_tick_gated: assert property (@(posedge clk) disable iff (rst)
    !bit_tick |=> ($stable(tx_bit) && $stable(busy) && $stable(bus_idle)));
endmodule

// File: tb/tb_can_gap_seq.sv
module tb_can_gap_seq;
  logic clk = 1'b0, rst = 1'b1, bit_tick = 1'b0, rx_bit = 1'b1;
  logic err_passive = 1'b0, err_req = 1'b0, ovl_req = 1'b0, was_tx = 1'b0;
  logic tx_bit, busy, bus_idle, ovl_flag, early_sof;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  can_gap_seq dut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .rx_bit(rx_bit),
    .err_passive(err_passive), .err_req(err_req), .ovl_req(ovl_req), .was_tx(was_tx),
    .tx_bit(tx_bit), .busy(busy), .bus_idle(bus_idle), .ovl_flag(ovl_flag),
    .early_sof(early_sof)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One bit period: the bus is this node's bit ANDed with the others' bit.
  task automatic step(input logic others, input logic er, input logic ov);
    @(negedge clk);
    rx_bit = tx_bit & others; err_req = er; ovl_req = ov; bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0; err_req = 1'b0; ovl_req = 1'b0; rx_bit = 1'b1;
  endtask

  task automatic gap_run(input int dom_len, output int t, output int lows);
    t = 0; lows = 0;
    for (int i = 1; i <= 80; i++) begin
      step(!(i <= dom_len), 1'b0, 1'b0);
      if (!tx_bit) lows++;
      if (bus_idle) begin t = i; break; end
    end
  endtask

  task automatic to_interm();
    err_passive = 1'b0;
    step(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 14; i++) step(1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    int t, lows;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9 reset tx_bit", tx_bit, 1);
    check("R9 reset busy", busy, 0);
    check("R9 reset bus_idle", bus_idle, 1);
    check("R9 reset pulses", {ovl_flag, early_sof}, 0);

    // R9 no tick, no change
    err_req = 1'b1; ovl_req = 1'b1; rx_bit = 1'b0;
    repeat (5) @(negedge clk);
    check("R9 untimed request tx_bit", tx_bit, 1);
    check("R9 untimed request busy", busy, 0);
    err_req = 1'b0; ovl_req = 1'b0; rx_bit = 1'b1;

    // R1, R3, R5: active flag with e extra dominant bits from others
    for (int e = 0; e <= 6; e++) begin
      err_passive = 1'b0;
      step(1'b1, 1'b1, 1'b0);
      check($sformatf("R1 active entry dominant e=%0d", e), tx_bit, 0);
      gap_run(6 + e, t, lows);
      check($sformatf("R1 active dominant count e=%0d", e), lows + 1, 6);
      check($sformatf("R3 R5 idle tick e=%0d", e), t, 17 + e);
    end

    // R2, R3: passive flag, d dominant bits from others first
    for (int d = 0; d <= 12; d++) begin
      err_passive = 1'b1;
      step(1'b1, 1'b1, 1'b0);
      check($sformatf("R2 passive entry busy d=%0d", d), {tx_bit, busy}, 3);
      gap_run(d, t, lows);
      check($sformatf("R2 passive drives no dominant d=%0d", d), lows, 0);
      check($sformatf("R2 R3 passive idle tick d=%0d", d), t, (d < 6) ? d + 17 : d + 11);
    end
    err_passive = 1'b0;

    // R4 overload from idle
    step(1'b1, 1'b0, 1'b1);
    check("R4 overload entry dominant", tx_bit, 0);
    gap_run(6, t, lows);
    check("R4 overload dominant count", lows + 1, 6);
    check("R4 overload idle tick", t, 17);

    // R6, R7: dominant at intermission bit j
    for (int j = 1; j <= 3; j++) begin
      to_interm();
      for (int k = 1; k < j; k++) step(1'b1, 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b0);
      if (j < 3) begin
        check($sformatf("R6 ovl_flag pulse bit %0d", j), ovl_flag, 1);
        check($sformatf("R6 overload dominant bit %0d", j), tx_bit, 0);
        gap_run(6, t, lows);
        check($sformatf("R6 overload idle tick bit %0d", j), t, 17);
      end else begin
        check("R7 early_sof pulse", early_sof, 1);
        check("R7 no ovl_flag", ovl_flag, 0);
        check("R7 back to idle", {bus_idle, tx_bit, busy}, 6);
        @(negedge clk);
        check("R7 pulse one clock", early_sof, 0);
      end
    end

    // R10: error during intermission, no gap first
    to_interm();
    step(1'b1, 1'b1, 1'b0);
    check("R10 error in intermission dominant", tx_bit, 0);
    gap_run(6, t, lows);
    check("R10 error in intermission idle tick", t, 17);

    // R10: error outranks overload (passive flag chosen)
    err_passive = 1'b1;
    step(1'b1, 1'b1, 1'b1);
    check("R10 priority recessive busy", {tx_bit, busy}, 3);
    gap_run(0, t, lows);
    check("R10 priority no dominant", lows, 0);
    check("R10 priority idle tick", t, 17);

    // R8 suspend period
    was_tx = 1'b1;
    step(1'b1, 1'b1, 1'b0);
    gap_run(0, t, lows);
    check("R8 suspend idle tick", t, 25);

    // R8 suspend cut short by dominant
    step(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 17; i++) step(1'b1, 1'b0, 1'b0);
    check("R8 in suspend busy not idle", {busy, bus_idle}, 2);
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    check("R8 suspend dominant early_sof", early_sof, 1);
    check("R8 suspend dominant idle", bus_idle, 1);
    was_tx = 1'b0; err_passive = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule